// File: doc/BRIEF.md
# Programmable Reference Clock Divider

This block sits between a reference oscillator (2 to 20 MHz) and a phase-frequency detector. It turns every reference clock edge into a step of a down-counter and emits a one-cycle comparison pulse each time the count runs out. The comparison rate is therefore the reference rate over a selected ratio, and it should stay at or below 4 MHz.

A 4-bit ratio code picks one of sixteen fixed ratios. The high bit picks the family. With the high bit clear, the ratios are the powers of two from 2 to 256. With the high bit set, the ratios are 3, 5 and then 5 doubled repeatedly up to 320. A new code takes effect only when the pulse of the current period is issued, so a period is never cut short and no narrow pulse appears.

For test, the comparison pulse can be routed to a general output pin in place of that pin's static level.

Top module: `refdiv_top`

## Requirements
- R1: While `rst_i` is high at a clock edge, `fcomp_o` is low after that edge.
- R2: With `code_i[3]` = 0 and `code_i[2:0]` = k, consecutive `fcomp_o` pulses are 2^(k+1) clock cycles apart. That gives 2, 4, 8 and so on up to 256.
- R3: With `code_i[3]` = 1, the spacing is 3 for `code_i[2:0]` = 0, and 5·2^(k-1) for `code_i[2:0]` = k ≥ 1. That gives 3, 5, 10, 20, 40, 80, 160 and 320.
- R4: Each `fcomp_o` pulse is exactly one clock cycle wide.
- R5: The gap from one pulse to the next equals the ratio of the code present at the clock edge that raised the first pulse. Code changes at any other edge have no effect on the period in progress.
- R6: The first clock edge with `rst_i` low raises `fcomp_o`.
- R7: With `test_en_i` = 1, `port_o` equals `fcomp_o` in the same cycle. With `test_en_i` = 0, `port_o` equals `port_level_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_i | input | 1 | Synchronous reset, active high |
| code_i | input | 4 | Ratio code: bit 3 is the family, bits 2:0 are the step |
| test_en_i | input | 1 | Routes the comparison pulse to `port_o` |
| port_level_i | input | 1 | Static level for `port_o` outside test routing |
| fcomp_o | output | 1 | Comparison-rate pulse, one cycle wide |
| port_o | output | 1 | General output pin |

## Verification
A corrupted count or reload value shows up as a pulse spacing that differs from the table. The error appears at the very next pulse, so at most 320 cycles after it occurs. A wrong sampling point for the code shows up as an early or late period, but only on the pulse that follows a code change. For that reason, the code is moved at many different offsets inside a period. Every cycle of `fcomp_o` and `port_o` is compared against a behavioural model, so an extra or missing pulse is reported in the cycle where it happens.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;

   typedef enum logic {
      FAM_BINARY = 1'b0,
      FAM_MIXED  = 1'b1
   } ratio_family_e;

   // Division ratio for a family and a step index.
   function automatic int unsigned ratio_of(input int unsigned fam, input int unsigned step);
      if (fam == 0)
         return 32'd2 << step;
      else if (step == 0)
         return 32'd3;
      else
         return 32'd5 << (step - 1);
   endfunction

   // Largest ratio reachable with a given step field width.
   function automatic int unsigned max_ratio(input int unsigned step_w);
      int unsigned best;
      best = 0;
      for (int unsigned f = 0; f < 2; f++) begin
         for (int unsigned s = 0; s < (32'd1 << step_w); s++) begin
            if (ratio_of(f, s) > best) best = ratio_of(f, s);
         end
      end
      return best;
   endfunction

   // Bits needed to hold the value v - 1 (a down-count start).
   function automatic int unsigned count_width(input int unsigned v);
      return (v <= 2) ? 1 : $clog2(v);
   endfunction

endpackage

// File: rtl/refdiv_ratio_rom.sv
module refdiv_ratio_rom
   import refdiv_pkg::*;
#(
   parameter int unsigned STEP_W = 3,
   parameter int unsigned CNT_W  = 9,
   parameter int unsigned STYLE  = 0
) (
   input  logic [STEP_W:0]   code_i,
   output logic [CNT_W-1:0]  reload_o
);

   localparam int unsigned ENTRIES = 32'd2 << STEP_W;
   localparam int unsigned STEPS   = 32'd1 << STEP_W;

   generate
      if (STYLE == 0) begin : g_table
         logic [CNT_W-1:0] tbl [ENTRIES];
         for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
            localparam int unsigned RV = ratio_of(g / STEPS, g % STEPS);
            assign tbl[g] = CNT_W'(RV - 1);
         end
         assign reload_o = tbl[code_i];
      end else begin : g_shift
         logic                fam;
         logic [STEP_W-1:0]   step;
         assign fam  = code_i[STEP_W];
         assign step = code_i[STEP_W-1:0];
         always_comb begin
            if (fam == FAM_BINARY)
               reload_o = (CNT_W'(2) << step) - CNT_W'(1);
            else if (step == '0)
               reload_o = CNT_W'(2);
            else
               reload_o = (CNT_W'(5) << (step - 1'b1)) - CNT_W'(1);
         end
      end
   endgenerate

endmodule

// File: rtl/refdiv_counter.sv
module refdiv_counter #(
   parameter int unsigned CNT_W = 9
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic [CNT_W-1:0]  reload_i,
   output logic              pulse_o
);

   logic [CNT_W-1:0] cnt_q;
   logic             at_term;

   assign at_term = (cnt_q == '0);

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         cnt_q   <= '0;
         pulse_o <= 1'b0;
      end else begin
         pulse_o <= at_term;
         if (at_term)
            cnt_q <= reload_i;
         else
            cnt_q <= cnt_q - 1'b1;
      end
   end

endmodule

// File: rtl/refdiv_top.sv
module refdiv_top
   import refdiv_pkg::*;
#(
   parameter int unsigned STEP_W       = 3,
   parameter int unsigned DECODE_STYLE = 0
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic [STEP_W:0]   code_i,
   input  logic              test_en_i,
   input  logic              port_level_i,
   output logic              fcomp_o,
   output logic              port_o
);

   localparam int unsigned TOP_RATIO = max_ratio(STEP_W);
   localparam int unsigned CNT_W     = count_width(TOP_RATIO);

   generate
      if (STEP_W < 1 || STEP_W > 6) begin : g_bad_step
         $error("refdiv_top: STEP_W must be 1..6");
      end
      if (DECODE_STYLE > 1) begin : g_bad_style
         $error("refdiv_top: DECODE_STYLE must be 0 or 1");
      end
      if ((32'd1 << CNT_W) < TOP_RATIO) begin : g_bad_width
         $error("refdiv_top: counter too narrow for the largest ratio");
      end
   endgenerate

   logic [CNT_W-1:0] reload;
   logic             pulse;

   refdiv_ratio_rom #(
      .STEP_W (STEP_W),
      .CNT_W  (CNT_W),
      .STYLE  (DECODE_STYLE)
   ) u_rom (
      .code_i   (code_i),
      .reload_o (reload)
   );

   refdiv_counter #(
      .CNT_W (CNT_W)
   ) u_cnt (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .reload_i (reload),
      .pulse_o  (pulse)
   );

   assign fcomp_o = pulse;
   assign port_o  = test_en_i ? pulse : port_level_i;

endmodule

// File: rtl/refdiv_checker.sv
module refdiv_checker #(
   parameter int unsigned STEP_W = 3
) (
   input logic              clk_i,
   input logic              rst_i,
   input logic [STEP_W:0]   code_i,
   input logic              test_en_i,
   input logic              port_level_i,
   input logic              fcomp_o,
   input logic              port_o
);

   function automatic int unsigned want_gap(input logic [STEP_W:0] c);
      int unsigned k;
      k = int'(c[STEP_W-1:0]);
      if (!c[STEP_W]) return 32'd1 << (k + 1);
      if (k == 0) return 32'd3;
      return 32'd5 * (32'd1 << (k - 1));
   endfunction

   logic [STEP_W:0] code_q;
   logic [15:0]     gap;
   logic [15:0]     exp_gap;
   logic            exp_mixed;
   logic            have_prev;
   logic            rst_q;

   always_ff @(posedge clk_i) begin
      code_q <= code_i;
      rst_q  <= rst_i;
      if (rst_i) begin
         gap       <= '0;
         exp_gap   <= '0;
         exp_mixed <= 1'b0;
         have_prev <= 1'b0;
      end else if (fcomp_o) begin
         gap       <= 16'd1;
         exp_gap   <= 16'(want_gap(code_q));
         exp_mixed <= code_q[STEP_W];
         have_prev <= 1'b1;
      end else if (gap != 16'hFFFF) begin
         gap <= gap + 16'd1;
      end
   end

   AST_RESET_SILENT: assert property (@(posedge clk_i) rst_i |=> !fcomp_o); // R1

   AST_BINARY_GAP: assert property (@(posedge clk_i) disable iff (rst_i)
      (fcomp_o && have_prev && !exp_mixed) |-> (gap == exp_gap)); // R2

   AST_MIXED_GAP: assert property (@(posedge clk_i) disable iff (rst_i)
      (fcomp_o && have_prev && exp_mixed) |-> (gap == exp_gap)); // R3

   AST_PULSE_NARROW: assert property (@(posedge clk_i) disable iff (rst_i)
      fcomp_o |=> !fcomp_o); // R4

   AST_NO_EARLY_PULSE: assert property (@(posedge clk_i) disable iff (rst_i)
      (have_prev && !fcomp_o && gap != 16'hFFFF) |-> (gap < exp_gap)); // R5

   AST_FIRST_PULSE: assert property (@(posedge clk_i) disable iff (rst_i)
      (rst_q && !rst_i) |=> fcomp_o); // R6

   AST_PORT_TEST: assert property (@(posedge clk_i) disable iff (rst_i)
      test_en_i |-> (port_o == fcomp_o)); // R7

   AST_PORT_STATIC: assert property (@(posedge clk_i) disable iff (rst_i)
      !test_en_i |-> (port_o == port_level_i)); // R7

endmodule

bind refdiv_top refdiv_checker #(.STEP_W(STEP_W)) u_chk (
   .clk_i        (clk_i),
   .rst_i        (rst_i),
   .code_i       (code_i),
   .test_en_i    (test_en_i),
   .port_level_i (port_level_i),
   .fcomp_o      (fcomp_o),
   .port_o       (port_o)
);

// File: tb/refdiv_top_tb.sv
module refdiv_top_tb;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [3:0] code = 4'b1011;
   logic       test_en = 1'b0;
   logic       port_level = 1'b0;
   logic       fcomp;
   logic       port;

   int unsigned vectors = 0;
   int unsigned errors  = 0;
   string       tag = "R1";
   bit          done = 1'b0;

   always #5 clk = ~clk;

   refdiv_top u_dut (
      .clk_i        (clk),
      .rst_i        (rst),
      .code_i       (code),
      .test_en_i    (test_en),
      .port_level_i (port_level),
      .fcomp_o      (fcomp),
      .port_o       (port)
   );

   function automatic int ratio_tbl(input logic [3:0] c);
      case (c)
         4'd0:  return 2;    4'd1:  return 4;
         4'd2:  return 8;    4'd3:  return 16;
         4'd4:  return 32;   4'd5:  return 64;
         4'd6:  return 128;  4'd7:  return 256;
         4'd8:  return 3;    4'd9:  return 5;
         4'd10: return 10;   4'd11: return 20;
         4'd12: return 40;   4'd13: return 80;
         4'd14: return 160;  default: return 320;
      endcase
   endfunction

   // Behavioural model: cycles left until the next pulse.
   int   left = 0;
   logic exp_f = 1'b0;

   always @(posedge clk) begin
      if (rst) begin
         left  = 0;
         exp_f = 1'b0;
      end else if (left == 0) begin
         exp_f = 1'b1;
         left  = ratio_tbl(code) - 1;
      end else begin
         exp_f = 1'b0;
         left  = left - 1;
      end
   end

   always @(negedge clk) begin
      if (!done) begin
         logic exp_p;
         exp_p = test_en ? exp_f : port_level;
         vectors++;
         if (fcomp !== exp_f) begin
            errors++;
            $display("FAIL %s fcomp_o actual=%b expected=%b code=%0d t=%0t", tag, fcomp, exp_f, code, $time);
         end
         vectors++;
         if (port !== exp_p) begin
            errors++;
            $display("FAIL %s port_o actual=%b expected=%b t=%0t", tag, port, exp_p, $time);
         end
      end
   end

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      // R1: reset holds the pulse low with a nonzero code applied
      tag = "R1";
      step(4);
      // R6: first edge after release raises the pulse
      rst = 1'b0;
      tag = "R6";
      step(3);
      // R2: binary family, every step
      tag = "R2";
      for (int k = 0; k < 8; k++) begin
         code = 4'(k);
         step(3 * ratio_tbl(4'(k)) + 260);
      end
      // R3: mixed family, every step
      tag = "R3";
      for (int k = 8; k < 16; k++) begin
         code = 4'(k);
         step(3 * ratio_tbl(4'(k)) + 330);
      end
      // R4: odd ratios, narrow pulse
      tag = "R4";
      code = 4'b1000;
      step(30);
      code = 4'b1001;
      step(30);
      // R5: code moved at many offsets inside a period
      tag = "R5";
      for (int i = 0; i < 60; i++) begin
         code = 4'((i * 7 + 3) % 16);
         step((i * 13) % 37 + 1);
      end
      code = 4'b0010;
      step(400);
      // R7: routing the pulse to the port
      tag = "R7";
      code = 4'b0000;
      for (int i = 0; i < 8; i++) begin
         test_en    = i[0];
         port_level = i[1];
         step(5);
      end
      test_en = 1'b0;
      // R1: reset again mid-run
      tag = "R1";
      code = 4'b1111;
      step(7);
      rst = 1'b1;
      step(5);
      rst = 1'b0;
      tag = "R6";
      step(650);
      finish_run();
   end

endmodule